// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block turns an asynchronous serial line into parallel characters. A one-cycle enable, pulsing at sixteen times the bit rate, paces all of its timing. On a falling edge of the line it waits to the middle of the start bit and checks again that the line is still low, which rejects glitches. It then samples 5 to 8 data bits, least significant bit first, followed by an optional parity bit and one stop bit. Every bit is sampled once, at its middle.

Each finished character goes into a one-byte holding register. The block also keeps five line-status flags beside that register: ready, overrun, parity error, framing error and break. The host reads the byte with a data-read strobe and clears the error flags with a status-read strobe. The format inputs (word length and the three parity controls) are captured when a start edge is seen, so they apply to that whole character.

Top module: `uart_rx_line`

## Requirements
- R1: A start is detected on a tick where the line was high at the previous tick and is low now. The line is checked again 7 ticks later. If it is high at that point, the receiver returns to idle and produces no character.
- R2: Data bits are sampled every 16 ticks after the start check, least significant bit first. `wlen_i` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. A loaded byte carries zeros above the word length.
- R3: With `par_en_i`=0 there is no parity bit. With `par_en_i`=1 and `par_force_i`=0, `par_even_i`=0 selects odd parity and 1 selects even parity, counted over the data bits and the parity bit together. With `par_force_i`=1, `par_even_i`=0 expects the parity bit to be 1 and `par_even_i`=1 expects it to be 0. A mismatch sets `parity_err_o`.
- R4: A stop bit sampled low sets `framing_err_o`.
- R5: A break is a frame in which every sampled bit, the stop bit included, is low. A break loads a zero byte and sets `break_o` and `framing_err_o`, with `parity_err_o` left at 0. No new start is accepted until the line has been high at a tick.
- R6: `ready_o` goes high when a character is loaded into the holding register. It goes low after a `rd_data_i` pulse.
- R7: If a character completes while `ready_o` is high and no data read is in the same cycle, `overrun_o` is set. The new character and its error flags are dropped, and `data_o` is unchanged.
- R8: The parity, framing and break flags are set together with the loaded character and stay set until they are cleared. A `rd_status_i` pulse clears `overrun_o`, `parity_err_o`, `framing_err_o` and `break_o`.
- R9: After reset, `data_o` is 0 and all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | One-cycle enable at 16x the bit rate |
| rx_i | input | 1 | Serial line, idle high |
| wlen_i | input | 2 | Word length select (5 + value) |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Even parity, or with force: expect 0 |
| par_force_i | input | 1 | Forced parity value |
| rd_data_i | input | 1 | Holding-register read strobe |
| rd_status_i | input | 1 | Status read strobe, clears error flags |
| data_o | output | 8 | Holding register |
| ready_o | output | 1 | Data ready |
| overrun_o | output | 1 | Overrun |
| parity_err_o | output | 1 | Parity error |
| framing_err_o | output | 1 | Framing error |
| break_o | output | 1 | Break received |

## Verification
The stop bit is sampled on a tick, at the middle of the stop bit. The character and its flags then appear two clock edges later: one edge registers the completion pulse and the next loads the holding register. A read strobe takes effect one edge after it is driven. The bench therefore drives each frame as whole 64-clock bit cells and keeps the line idle for one more full bit before it compares the outputs on a falling clock edge. Each read pulse is followed by a cycle of settling before the flags are checked. Because of this, no check lies near the edge on which a result changes, and the bench does not depend on the exact tick phase of the start detection.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  parameter int CHAR_W = 8;
  localparam int IDX_W = $clog2(CHAR_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRKW
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_char_t;
endpackage

// File: rtl/rx_deframer.sv
module rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       par_force_i,
  output logic       done_o,
  output rx_char_t   char_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] START_LAST = CW'(OSR / 2 - 2);
  localparam logic [CW-1:0] BIT_LAST   = CW'(OSR - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [CHAR_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        wl_q;
  logic              pen_q, peven_q, pforce_q;
  logic              rx_prev_q, pbit_q, zero_q, done_q;
  rx_char_t          char_q;

  logic [IDX_W-1:0]  nb;
  logic [CHAR_W-1:0] data_c;
  logic              par_exp, brk_c, samp;

  always_comb begin
    nb      = IDX_W'(5) + IDX_W'(wl_q);
    data_c  = sh_q >> (IDX_W'(CHAR_W) - nb);
    par_exp = pforce_q ? ~peven_q : (peven_q ? ^data_c : ~^data_c);
    brk_c   = zero_q & ~rx_i;
    samp    = tick_i && (cnt_q == BIT_LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      idx_q     <= '0;
      wl_q      <= '0;
      pen_q     <= 1'b0;
      peven_q   <= 1'b0;
      pforce_q  <= 1'b0;
      rx_prev_q <= 1'b1;
      pbit_q    <= 1'b0;
      zero_q    <= 1'b1;
      done_q    <= 1'b0;
      char_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) rx_prev_q <= rx_i;
      case (state_q)
        ST_IDLE: if (tick_i && rx_prev_q && !rx_i) begin
          state_q  <= ST_START;
          cnt_q    <= '0;
          wl_q     <= wlen_i;
          pen_q    <= par_en_i;
          peven_q  <= par_even_i;
          pforce_q <= par_force_i;
        end
        ST_START: if (tick_i) begin
          if (cnt_q == START_LAST) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            zero_q <= 1'b1;
            state_q <= rx_i ? ST_IDLE : ST_DATA;  // false start rejected
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DATA: if (samp) begin
          cnt_q  <= '0;
          sh_q   <= {rx_i, sh_q[CHAR_W-1:1]};
          zero_q <= zero_q & ~rx_i;
          idx_q  <= idx_q + 1'b1;
          if (idx_q == nb - 1'b1) state_q <= pen_q ? ST_PAR : ST_STOP;
        end else if (tick_i) cnt_q <= cnt_q + 1'b1;
        ST_PAR: if (samp) begin
          cnt_q   <= '0;
          pbit_q  <= rx_i;
          zero_q  <= zero_q & ~rx_i;
          state_q <= ST_STOP;
        end else if (tick_i) cnt_q <= cnt_q + 1'b1;
        ST_STOP: if (samp) begin
          cnt_q       <= '0;
          done_q      <= 1'b1;
          char_q.data <= brk_c ? '0 : data_c;
          char_q.perr <= ~brk_c & pen_q & (pbit_q != par_exp);
          char_q.ferr <= ~rx_i;
          char_q.brk  <= brk_c;
          state_q     <= brk_c ? ST_BRKW : ST_IDLE;
        end else if (tick_i) cnt_q <= cnt_q + 1'b1;
        ST_BRKW: if (tick_i && rx_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign char_o = char_q;

  // the sequencer only moves on a tick
  assert_tick_paced_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q));

  // after a break no start is taken while the line stays low
  assert_break_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BRKW) && !rx_i |=> state_q == ST_BRKW);
endmodule

// File: rtl/rx_hold_status.sv
module rx_hold_status
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  rx_char_t          char_i,
  input  logic              rd_data_i,
  input  logic              rd_status_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              ready_o,
  output logic              overrun_o,
  output logic              parity_err_o,
  output logic              framing_err_o,
  output logic              break_o
);
  logic [CHAR_W-1:0] data_q;
  logic dr_q, oe_q, pe_q, fe_q, bi_q;
  logic full, load, keep;

  always_comb begin
    full = dr_q & ~rd_data_i;
    load = done_i & ~full;
    keep = ~rd_status_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dr_q   <= 1'b0;
      oe_q   <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      bi_q   <= 1'b0;
    end else begin
      dr_q <= load | full;
      oe_q <= (oe_q & keep) | (done_i & full);
      if (load) begin
        data_q <= char_i.data;
        pe_q   <= (pe_q & keep) | char_i.perr;
        fe_q   <= (fe_q & keep) | char_i.ferr;
        bi_q   <= (bi_q & keep) | char_i.brk;
      end else begin
        pe_q <= pe_q & keep;
        fe_q <= fe_q & keep;
        bi_q <= bi_q & keep;
      end
    end
  end

  assign data_o        = data_q;
  assign ready_o       = dr_q;
  assign overrun_o     = oe_q;
  assign parity_err_o  = pe_q;
  assign framing_err_o = fe_q;
  assign break_o       = bi_q;

  assert_overrun_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && dr_q && !rd_data_i |=> $stable(data_q) && oe_q);

  assert_ready_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> dr_q);

  assert_ready_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_i && !done_i |=> !dr_q);

  assert_status_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_status_i && !done_i |=> !(oe_q || pe_q || fe_q || bi_q));

  assert_break_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bi_q) |-> (data_q == '0) && fe_q);
endmodule

// File: rtl/uart_rx_line.sv
module uart_rx_line
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick16_i,
  input  logic       rx_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       par_force_i,
  input  logic       rd_data_i,
  input  logic       rd_status_i,
  output logic [7:0] data_o,
  output logic       ready_o,
  output logic       overrun_o,
  output logic       parity_err_o,
  output logic       framing_err_o,
  output logic       break_o
);
  logic     done;
  rx_char_t ch;

  rx_deframer #(.OSR(OSR)) i_deframer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick16_i),
    .rx_i        (rx_i),
    .wlen_i      (wlen_i),
    .par_en_i    (par_en_i),
    .par_even_i  (par_even_i),
    .par_force_i (par_force_i),
    .done_o      (done),
    .char_o      (ch)
  );

  rx_hold_status i_hold (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .done_i        (done),
    .char_i        (ch),
    .rd_data_i     (rd_data_i),
    .rd_status_i   (rd_status_i),
    .data_o        (data_o),
    .ready_o       (ready_o),
    .overrun_o     (overrun_o),
    .parity_err_o  (parity_err_o),
    .framing_err_o (framing_err_o),
    .break_o       (break_o)
  );
endmodule

// File: tb/test_uart_rx_line.sv
module test_uart_rx_line;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic pen = 1'b0, peven = 1'b0, pforce = 1'b0, rd_d = 1'b0, rd_s = 1'b0;
  logic [7:0] dout;
  logic rdy, oe, pe, fe, bi;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uart_rx_line i_uart_rx_line (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(tick), .rx_i(rx), .wlen_i(wlen),
    .par_en_i(pen), .par_even_i(peven), .par_force_i(pforce),
    .rd_data_i(rd_d), .rd_status_i(rd_s), .data_o(dout), .ready_o(rdy),
    .overrun_o(oe), .parity_err_o(pe), .framing_err_o(fe), .break_o(bi)
  );

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == TDIV - 1);
      c = (c + 1) % TDIV;
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic par_bit(logic [7:0] d, logic even, logic force_p);
    if (force_p) return ~even;
    return even ? ^d : ~^d;
  endfunction

  task automatic cells(logic v, int n);
    rx = v;
    repeat (n * BITC) @(negedge clk);
  endtask

  // one frame followed by one idle bit cell
  task automatic send(logic [7:0] d, logic [1:0] wl, logic p_en, logic p_ev,
                      logic p_fo, logic flip, logic stop_v);
    int nb = 5 + int'(wl);
    wlen = wl; pen = p_en; peven = p_ev; pforce = p_fo;
    cells(1'b0, 1);
    for (int i = 0; i < nb; i++) cells(d[i], 1);
    if (p_en) cells(par_bit(d & 8'((1 << nb) - 1), p_ev, p_fo) ^ flip, 1);
    cells(stop_v, 1);
    cells(1'b1, 1);
  endtask

  task automatic pulse_rd(logic d, logic s);
    rd_d = d; rd_s = s;
    @(negedge clk);
    rd_d = 0; rd_s = 0;
    @(negedge clk);
  endtask

  task automatic chk_flags(string req, logic e_rdy, logic e_oe, logic e_pe,
                           logic e_fe, logic e_bi);
    chk(req, "ready", 8'(rdy), 8'(e_rdy));
    chk(req, "overrun", 8'(oe), 8'(e_oe));
    chk(req, "parity_err", 8'(pe), 8'(e_pe));
    chk(req, "framing_err", 8'(fe), 8'(e_fe));
    chk(req, "break", 8'(bi), 8'(e_bi));
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R9: reset state
    chk("R9", "data", dout, 8'h00);
    chk_flags("R9", 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    cells(1'b1, 2);

    // R1: short low pulse is rejected
    rx = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    cells(1'b1, 3);
    chk_flags("R1", 0, 0, 0, 0, 0);

    // R2: plain 8-bit character
    send(8'hA5, 2'd3, 0, 0, 0, 0, 1);
    chk("R2", "data 8b", dout, 8'hA5);
    chk_flags("R2", 1, 0, 0, 0, 0);
    pulse_rd(1, 0);
    chk("R6", "ready after read", 8'(rdy), 8'h0);

    // R2: 5-bit word, upper bits zero
    send(8'hFF, 2'd0, 0, 0, 0, 0, 1);
    chk("R2", "data 5b", dout, 8'h1F);
    pulse_rd(1, 1);

    // R3: forced parity, both values, correct and wrong
    send(8'h3C, 2'd3, 1, 0, 1, 0, 1);
    chk("R3", "force1 ok", 8'(pe), 8'h0);
    pulse_rd(1, 1);
    send(8'h3C, 2'd3, 1, 1, 1, 1, 1);
    chk("R3", "force0 wrong", 8'(pe), 8'h1);
    pulse_rd(1, 1);

    // R4: bad stop bit
    send(8'h41, 2'd3, 0, 0, 0, 0, 0);
    chk("R4", "data", dout, 8'h41);
    chk_flags("R4", 1, 0, 0, 1, 0);
    pulse_rd(1, 1);
    chk_flags("R8", 0, 0, 0, 0, 0);

    // R7: overrun keeps the first byte
    send(8'h11, 2'd3, 0, 0, 0, 0, 1);
    send(8'h22, 2'd3, 1, 0, 0, 1, 1);
    chk("R7", "held byte", dout, 8'h11);
    chk_flags("R7", 1, 1, 0, 0, 0);
    pulse_rd(1, 1);
    chk_flags("R7", 0, 0, 0, 0, 0);

    // R8: error flag sticks over a clean character
    send(8'h5A, 2'd3, 1, 1, 0, 1, 1);
    pulse_rd(1, 0);
    send(8'h66, 2'd3, 0, 0, 0, 0, 1);
    chk("R8", "new byte", dout, 8'h66);
    chk_flags("R8", 1, 0, 1, 0, 0);
    pulse_rd(1, 1);
    chk_flags("R8", 0, 0, 0, 0, 0);

    // R5: long break, one zero character only
    send(8'h77, 2'd3, 0, 0, 0, 0, 1);
    pulse_rd(1, 1);
    wlen = 2'd3; pen = 1'b1; peven = 1'b0; pforce = 1'b0;
    cells(1'b0, 24);
    chk("R5", "data", dout, 8'h00);
    chk_flags("R5", 1, 0, 0, 1, 1);
    pulse_rd(1, 1);
    cells(1'b0, 12);
    chk_flags("R5", 0, 0, 0, 0, 0);
    cells(1'b1, 1);
    send(8'h9C, 2'd3, 0, 0, 0, 0, 1);
    chk("R5", "after break", dout, 8'h9C);
    pulse_rd(1, 1);

    // random frames
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d = 8'($urandom);
      logic [1:0] wl = 2'($urandom);
      logic p_en = 1'($urandom), p_ev = 1'($urandom), p_fo = 1'($urandom);
      logic flip = ($urandom % 4) == 0;
      logic stop_v = ($urandom % 8) != 0;
      int nb = 5 + int'(wl);
      logic [7:0] dm, pb;
      logic brk;
      if (($urandom % 6) == 0) d = 8'h00;
      dm = d & 8'((1 << nb) - 1);
      pb = 8'(par_bit(dm, p_ev, p_fo) ^ flip);
      brk = (dm == 0) && (!p_en || pb == 0) && !stop_v;
      send(d, wl, p_en, p_ev, p_fo, flip, stop_v);
      chk("R2", "rand data", dout, brk ? 8'h00 : dm);
      chk_flags("R3", 1, 0, !brk && p_en && flip, !stop_v, brk);
      pulse_rd(1, 1);
      chk_flags("R6", 0, 0, 0, 0, 0);
    end
    finish_run();
  end
endmodule